// File: doc/BRIEF.md
# Synchronous Burst Read Clock Generator

This block runs synchronous burst reads from a NOR Flash or PSRAM device. A one-cycle start request latches a word address, a beat count, a clock divide setting, an initial latency and a turnaround length. The block then pulls the chip select low. It builds a memory clock from whole system clock cycles and lets a programmed number of memory clock edges pass before it takes any data. After that it takes one 16-bit word on each later rising memory clock edge until the requested number of words has been delivered.

The memory can hold off a beat by driving its active-low wait line. A rising edge seen while wait is asserted delivers nothing, and the beat moves to the next edge. When the last beat has been taken, the memory clock finishes its current period and parks low, and the chip select is released. A short turnaround interval follows, and a one-cycle done pulse marks the point where a new request may be issued. The captured words leave the block on a valid-flagged 16-bit stream.

Top module: `sbr_clkgen`

## Requirements
- R1: After reset, and whenever no burst is in progress, `mem_clk` is low, `mem_cs_n` is high, and `rd_valid`, `busy` and `done` are low.
- R2: The memory clock period is `div_sel`+1 system clocks (4-bit field, 1..15 giving 2..16). Each period is high for floor(period/2) system clocks and low for the rest. A `div_sel` of 0 behaves like 1 (period of 2).
- R3: `mem_cs_n` falls exactly one system clock before the first rising edge of `mem_clk`. `mem_addr` carries the address latched at start and stays stable while `mem_cs_n` is low.
- R4: The latency is L = `lat_sel`+2 memory clocks (4-bit field, giving 2..17). The first L rising edges deliver no data, and the earliest capture happens at rising edge L+1.
- R5: The value on `mem_data` during the system clock cycle in which `mem_clk` rises (on a capture edge) appears on `rd_data`, with `rd_valid` high for exactly one cycle, in the next system clock cycle.
- R6: `mem_wait_n` is active low and registered once. A rising edge after the latency, for which the registered wait is low, captures nothing, and the beat moves to the next rising edge. Wait has no effect on latency edges.
- R7: A burst delivers exactly `len_sel`+1 beats (4-bit field, giving 1..16). The number of rising edges is L + beats + stalled edges. After the last beat the clock completes its period and stays low, and `mem_cs_n` rises at the end of that period.
- R8: `done` is a one-cycle pulse issued exactly `turn_sel`+1 system clocks after `mem_cs_n` rises, and `busy` is low in that cycle.
- R9: A start request that arrives while a burst is in progress is ignored. No second burst follows, and the configuration latched for the running burst is unchanged.
- R10: `mem_clk` toggles only while `mem_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle burst request, honoured only when idle |
| rd_addr | input | AW | Word address of the burst |
| div_sel | input | DIV_W | Memory clock period minus one, in system clocks |
| lat_sel | input | LAT_W | Initial latency minus two, in memory clocks |
| len_sel | input | LEN_W | Beat count minus one |
| turn_sel | input | TURN_W | Turnaround length minus one, in system clocks |
| mem_wait_n | input | 1 | Memory wait request, active low |
| mem_data | input | DW | Read data from the memory |
| mem_clk | output | 1 | Memory clock |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_addr | output | AW | Address to the memory |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DW | Captured word |
| busy | output | 1 | Burst or turnaround in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
Every divide setting from 0 to 15 is swept with a fixed beat count, which exposes period, duty and chip-select lead errors at both odd and even ratios. Every latency setting is then swept at the fastest clock, and the cycle of the first valid word shows whether the capture edge is off by one. Every beat count is swept to check the stop point and the turnaround timing. Wait patterns (a single stall, back-to-back stalls, alternating stalls, and a stall on a latency edge) separate correct beat slipping from dropped or duplicated words. A second start issued in the middle of a burst shows that requests are ignored while busy.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_TURN  = 2'd3
    } sbr_state_e;

endpackage

// File: rtl/sbr_phase_gen.sv
module sbr_phase_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] period_m1,
    output logic             mem_clk,
    output logic             rise,
    output logic             last
);

    typedef struct packed {
        logic             on;
        logic             clk_out;
        logic [DIV_W-1:0] ph;
    } ph_state_t;

    ph_state_t  st_d, st_q;
    logic [DIV_W:0] half;

    // number of high cycles per period: floor(period/2)
    assign half = ({1'b0, period_m1} + 1'b1) >> 1;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.on      = 1'b0;
            st_d.ph      = '0;
            st_d.clk_out = 1'b0;
        end else begin
            st_d.on = 1'b1;
            if (!st_q.on || st_q.ph == period_m1) begin
                st_d.ph = '0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
            st_d.clk_out = ({1'b0, st_d.ph} < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_clk = st_q.clk_out;
    assign rise    = st_q.on && (st_q.ph == '0);
    assign last    = st_q.on && (st_q.ph == period_m1);

endmodule

// File: rtl/sbr_beat_ctrl.sv
module sbr_beat_ctrl #(
    parameter int LAT_W = 4,
    parameter int LEN_W = 4,
    parameter int DW    = 16,
    localparam int LE_W = LAT_W + 1,
    localparam int BC_W = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rise,
    input  logic [LE_W-1:0]  lat_edges,
    input  logic [LEN_W-1:0] beats_m1,
    input  logic             wait_asserted,
    input  logic [DW-1:0]    mem_data,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             fin
);

    typedef struct packed {
        logic [LE_W-1:0] ec;
        logic [BC_W-1:0] bc;
        logic            fin;
        logic            vld;
        logic [DW-1:0]   data;
    } beat_state_t;

    beat_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clear) begin
            st_d.ec  = '0;
            st_d.bc  = '0;
            st_d.fin = 1'b0;
        end else if (rise && !st_q.fin) begin
            if (st_q.ec < lat_edges) begin
                // latency edge: counted, wait ignored
                st_d.ec = st_q.ec + 1'b1;
            end else if (!wait_asserted) begin
                st_d.vld  = 1'b1;
                st_d.data = mem_data;
                st_d.bc   = st_q.bc + 1'b1;
                if (st_q.bc == {1'b0, beats_m1}) begin
                    st_d.fin = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.vld;
    assign rd_data  = st_q.data;
    assign fin      = st_q.fin;

endmodule

// File: rtl/sbr_clkgen.sv
module sbr_clkgen #(
    parameter int AW     = 26,
    parameter int DW     = 16,
    parameter int DIV_W  = 4,
    parameter int LAT_W  = 4,
    parameter int LEN_W  = 4,
    parameter int TURN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     rd_addr,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [LAT_W-1:0]  lat_sel,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic [TURN_W-1:0] turn_sel,
    input  logic              mem_wait_n,
    input  logic [DW-1:0]     mem_data,
    output logic              mem_clk,
    output logic              mem_cs_n,
    output logic [AW-1:0]     mem_addr,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              busy,
    output logic              done
);

    import sbr_pkg::*;

    localparam int LE_W = LAT_W + 1;

    typedef struct packed {
        sbr_state_e        state;
        logic              cs_n;
        logic [AW-1:0]     addr;
        logic [DIV_W-1:0]  pm1;
        logic [LE_W-1:0]   lat_edges;
        logic [LEN_W-1:0]  beats_m1;
        logic [TURN_W-1:0] turn;
        logic [TURN_W-1:0] tc;
        logic              wait_n;
        logic              done;
    } top_state_t;

    top_state_t st_d, st_q;

    logic run, clear, rise, last, fin;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.wait_n = mem_wait_n;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state     = ST_SETUP;
                    st_d.cs_n      = 1'b0;
                    st_d.addr      = rd_addr;
                    st_d.pm1       = (div_sel == '0) ? DIV_W'(1) : div_sel;
                    st_d.lat_edges = {1'b0, lat_sel} + LE_W'(2);
                    st_d.beats_m1  = len_sel;
                    st_d.turn      = turn_sel;
                end
            end
            ST_SETUP: begin
                st_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (fin && last) begin
                    st_d.state = ST_TURN;
                    st_d.cs_n  = 1'b1;
                    st_d.tc    = st_q.turn;
                end
            end
            ST_TURN: begin
                if (st_q.tc == '0) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.tc = st_q.tc - 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.state  <= ST_IDLE;
            st_q.cs_n   <= 1'b1;
            st_q.pm1    <= DIV_W'(1);
            st_q.wait_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run   = (st_q.state == ST_SETUP) ||
                   ((st_q.state == ST_RUN) && !(fin && last));
    assign clear = (st_q.state == ST_IDLE);

    sbr_phase_gen #(
        .DIV_W (DIV_W)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .period_m1 (st_q.pm1),
        .mem_clk   (mem_clk),
        .rise      (rise),
        .last      (last)
    );

    sbr_beat_ctrl #(
        .LAT_W (LAT_W),
        .LEN_W (LEN_W),
        .DW    (DW)
    ) i_beat (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (clear),
        .rise          (rise),
        .lat_edges     (st_q.lat_edges),
        .beats_m1      (st_q.beats_m1),
        .wait_asserted (!st_q.wait_n),
        .mem_data      (mem_data),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .fin           (fin)
    );

    assign mem_cs_n = st_q.cs_n;
    assign mem_addr = st_q.addr;
    assign busy     = (st_q.state != ST_IDLE);
    assign done     = st_q.done;

endmodule

// File: rtl/sbr_clkgen_chk.sv
module sbr_clkgen_chk #(
    parameter int AW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_clk,
    input logic          mem_cs_n,
    input logic [AW-1:0] mem_addr,
    input logic          rd_valid,
    input logic          busy,
    input logic          done
);

    AST_CLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> !mem_clk);                                     // R10

    AST_CS_LEADS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |=> mem_clk);                               // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));     // R3

    AST_VALID_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !mem_cs_n);                                    // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && mem_cs_n));                              // R8

    AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> busy);                                        // R1

endmodule

bind sbr_clkgen sbr_clkgen_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_clk  (mem_clk),
    .mem_cs_n (mem_cs_n),
    .mem_addr (mem_addr),
    .rd_valid (rd_valid),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_sbr_clkgen.sv
module test_sbr_clkgen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 26;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] rd_addr;
    logic [3:0]    div_sel, lat_sel, len_sel, turn_sel;
    logic          mem_wait_n;
    logic [DW-1:0] mem_data;
    logic          mem_clk, mem_cs_n, rd_valid, busy, done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    sbr_clkgen i_sbr_clkgen (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
        .div_sel(div_sel), .lat_sel(lat_sel), .len_sel(len_sel), .turn_sel(turn_sel),
        .mem_wait_n(mem_wait_n), .mem_data(mem_data),
        .mem_clk(mem_clk), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat_word(input int k);
        return {8'h5C, 8'(k)};
    endfunction

    task automatic check_idle(input string tag);
        check(!mem_clk && mem_cs_n && !rd_valid && !busy && !done, tag,
              {27'd0, mem_clk, mem_cs_n, rd_valid, busy, done}, 8);
    endtask

    task automatic run_burst(input int div, input int lat, input int len, input int turn,
                             input logic [63:0] stall, input logic [AW-1:0] a,
                             input bit restart);
        int p, lat_n, beats, k0, s, got, kk, exp_edges;
        int edges, nvalid, exp_k, last_rise, first_rise, first_valid;
        int cs_fall, cs_rise, done_cyc, done_cnt, period_bad, hiw, hi_bad;
        int data_bad, clk_idle, addr_bad;
        logic prev_clk, prev_cs;
        p     = (div == 0) ? 2 : div + 1;
        lat_n = lat + 2;
        beats = len + 1;
        k0 = lat_n + 1;
        while (stall[k0]) k0++;
        s = 0; got = 0; kk = lat_n + 1;
        while (got < beats) begin
            if (stall[kk]) s++; else got++;
            kk++;
        end
        exp_edges = lat_n + beats + s;
        edges = 0; nvalid = 0; last_rise = 0; first_rise = -1; first_valid = -1;
        cs_fall = -1; cs_rise = -1; done_cyc = -1; done_cnt = 0;
        period_bad = 0; hiw = 0; hi_bad = 0; data_bad = 0; clk_idle = 0; addr_bad = 0;
        exp_k = k0;
        prev_clk = 1'b0; prev_cs = 1'b1;

        @(negedge clk);
        div_sel = 4'(div); lat_sel = 4'(lat); len_sel = 4'(len); turn_sel = 4'(turn);
        rd_addr = a; mem_wait_n = !stall[1]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && done_cnt == 0; i++) begin
            if (mem_clk && !prev_clk) begin
                edges++;
                if (edges == 1) begin
                    first_rise = cyc;
                    if (mem_addr != a) addr_bad++;
                end else if (cyc - last_rise != p) period_bad++;
                last_rise  = cyc;
                hiw        = 0;
                mem_data   = beat_word(edges);
                mem_wait_n = (edges + 1 < 64) ? !stall[edges + 1] : 1'b1;
            end
            if (mem_clk) hiw++;
            if (!mem_clk && prev_clk && hiw != p / 2) hi_bad++;
            if (mem_cs_n && mem_clk) clk_idle++;
            if (!mem_cs_n && prev_cs) cs_fall = cyc;
            if (mem_cs_n && !prev_cs) cs_rise = cyc;
            if (rd_valid) begin
                if (first_valid < 0) first_valid = cyc;
                nvalid++;
                if (rd_data != beat_word(exp_k)) data_bad++;
                exp_k++;
                while (exp_k < 64 && stall[exp_k]) exp_k++;
            end
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (restart && i == 4) begin
                start = 1'b1; div_sel = 4'd9; len_sel = 4'd12; rd_addr = ~a;
            end
            if (restart && i == 5) start = 1'b0;
            prev_clk = mem_clk; prev_cs = mem_cs_n;
            @(negedge clk);
        end

        check(cs_fall >= 0 && first_rise == cs_fall + 1, "R3 cs lead", first_rise - cs_fall, 1);
        check(addr_bad == 0, "R3 address", addr_bad, 0);
        check(period_bad == 0, "R2 period", period_bad, 0);
        check(hi_bad == 0, "R2 high width", hi_bad, 0);
        check(first_valid == first_rise + (k0 - 1) * p + 1, "R4 first beat cycle",
              first_valid, first_rise + (k0 - 1) * p + 1);
        if (stall != 64'd0) check(data_bad == 0, "R6 stalled data", data_bad, 0);
        else                check(data_bad == 0, "R5 data", data_bad, 0);
        check(nvalid == beats, "R7 beat count", nvalid, beats);
        check(edges == exp_edges, "R7 edge count", edges, exp_edges);
        check(cs_rise == last_rise + p, "R7 clock stop", cs_rise, last_rise + p);
        check(done_cnt == 1 && done_cyc == cs_rise + turn + 1, "R8 turnaround",
              done_cyc - cs_rise, turn + 1);
        check(!busy, "R8 busy at done", int'(busy), 0);
        check(clk_idle == 0, "R10 clock while deselected", clk_idle, 0);

        for (int j = 0; j < (restart ? 20 : 2); j++) begin
            @(negedge clk);
            if (!mem_cs_n || mem_clk || busy || done) clk_idle++;
        end
        if (restart) check(clk_idle == 0, "R9 start ignored while busy", clk_idle, 0);
        else         check_idle("R1 idle after burst");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; rd_addr = '0; div_sel = '0; lat_sel = '0;
        len_sel = '0; turn_sel = '0; mem_wait_n = 1'b1; mem_data = '0;
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R2: every divide setting
        for (int d = 0; d < 16; d++) run_burst(d, 0, 3, d, 64'd0, AW'(26'h100 + d), 1'b0);
        // R4: every latency setting at fastest clock
        for (int l = 0; l < 16; l++) run_burst(1, l, 0, 0, 64'd0, AW'(26'h2000 + l), 1'b0);
        run_burst(15, 15, 2, 15, 64'd0, 26'h3FFFFFF, 1'b0);
        // R7: every beat count
        for (int n = 0; n < 16; n++) run_burst(2, 1, n, n, 64'd0, AW'(26'h155 + n), 1'b0);
        // R6: wait patterns, including a stall request on a latency edge
        run_burst(1, 0, 3, 0, 64'h8,   26'h11, 1'b0);
        run_burst(1, 0, 3, 0, 64'h30,  26'h12, 1'b0);
        run_burst(4, 0, 3, 2, 64'hAA8, 26'h13, 1'b0);
        run_burst(3, 3, 2, 1, 64'h4,   26'h14, 1'b0);
        run_burst(2, 0, 0, 0, 64'h38,  26'h15, 1'b0);
        // R9: second start mid-burst
        run_burst(3, 2, 2, 1, 64'd0, 26'h0ABCDE, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule